// File: doc/BRIEF.md
# Split-Address Identification Register Reader

This block reads three identification bytes from a target device on a two-wire serial bus. The target has one unusual property: it takes a register selection on one bus address and returns the register contents on a different bus address. For each register, the block first sends a one-byte write that carries the register offset to the selection address. It closes that transaction with a STOP. It then sends a separate one-byte read to the data address. The registers at offsets 0, 1 and 2 are fetched in that order and kept as the first identifier, the second identifier and the version byte.

The block does not drive the bus pins. It hands whole single-byte transactions to a byte-level bus master through a valid/ready command channel and receives one response per command. Each response carries a NACK flag and the byte that was read. When all three reads succeed, the block decodes the version byte into a version code and a memory size in kilobytes; the meaning of the size field depends on the version code. It then checks the first identifier against the expected value and reports a result code together with an error flag. A failed transaction stops the sequence at once.

A run starts with a one-cycle `start` request. The results are valid while `done` is high, and `done` stays high until the next run is accepted.

Top module: `sar_idreader`

## Requirements
- R1: A write command (`cmd_rd`=0) always goes to 7-bit address 0x5A. A read command (`cmd_rd`=1) always goes to 7-bit address 0x35.
- R2: Every command has `cmd_stop`=1. Each register read is one write command followed by one read command. At most one command is outstanding: no new command is offered until the response to the previous one has arrived. A run issues at most six commands.
- R3: The write commands carry offsets 0x00, 0x01 and 0x02 in `cmd_wdata`, in that order. The bytes returned by the following reads appear on `id1`, `id2` and `ver_byte`. The data byte of a write response is ignored.
- R4: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr`, `cmd_rd` and `cmd_wdata` hold their values.
- R5: `ver_code` equals bits [2:0] of `ver_byte`. Bit 3 has no effect. The size code is bits [7:4].
- R6: For version codes 0, 1 and 2, size codes 0, 4 and 8 give `size_kb` 128, 192 and 256 with `size_stat`=0. Any other size code gives `size_stat`=1 and `size_kb`=0.
- R7: For version code 3, size codes 0, 2, 4, 6 and 8 give `size_kb` 128, 192, 256, 384 and 512 with `size_stat`=0. Any other size code gives `size_stat`=1 and `size_kb`=0.
- R8: A version code of 4 or above gives `size_stat`=2 and `size_kb`=0.
- R9: When all transactions succeed, `result` is 0 if `id1`=0x83 and 2 otherwise. `err` is high exactly when `result` is not 0.
- R10: A NACK on any response ends the run after that response. In that case `result`=1, `err`=1, `size_stat`=3, `size_kb`=0, and bytes that were not read stay 0.
- R11: `start` is accepted only while `busy` is low. A `start` while busy is ignored and is not held for later. `done` falls, and `busy` rises, in the cycle after an accepted `start`. `done` then stays high with `busy` low from the end of a run until the next accepted `start`.
- R12: After reset: `busy`=0, `done`=0, `cmd_valid`=0, `id1`=`id2`=`ver_byte`=0, `result`=0, `err`=0, `size_kb`=0 and `size_stat`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a read sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Results valid; held until next accepted start |
| cmd_valid | output | 1 | Command offered to the byte master |
| cmd_ready | input | 1 | Byte master accepts the command |
| cmd_addr | output | 7 | 7-bit target address of the command |
| cmd_rd | output | 1 | 1 = one-byte read, 0 = one-byte write |
| cmd_wdata | output | 8 | Byte to write (register offset) |
| cmd_stop | output | 1 | End the transaction with STOP |
| rsp_valid | input | 1 | Response for the outstanding command |
| rsp_nack | input | 1 | Transaction failed |
| rsp_rdata | input | 8 | Byte returned by a read |
| id1 | output | 8 | Register at offset 0 |
| id2 | output | 8 | Register at offset 1 |
| ver_byte | output | 8 | Register at offset 2 |
| ver_code | output | 3 | Decoded version code |
| size_kb | output | 10 | Decoded memory size in KB |
| size_stat | output | 2 | 0 valid, 1 bad size code, 2 unknown version, 3 not decoded |
| result | output | 2 | 0 ok, 1 bus failure, 2 identifier mismatch |
| err | output | 1 | Error flag |

## Verification
A new `start` request and the final response of a run can reach the block in the same cycle. In that case the block must finish the run it is doing, and it must not begin a second one or keep the request for later. The bench provokes this by raising `start` in the same cycle the byte-master stub returns its last response, whether that is a good last read or an early NACK. A `start` is also pulsed in the middle of some runs. The outcome is judged at the ports. The command count must stay at the expected value for several cycles after `done`, `done` must remain high with `busy` low, and the decoded results must match those computed for the single run.

// File: rtl/sar_pkg.sv
package sar_pkg;

   // result codes
   localparam logic [1:0] RES_OK  = 2'd0;
   localparam logic [1:0] RES_BUS = 2'd1;
   localparam logic [1:0] RES_ID  = 2'd2;

   // size decode status codes
   localparam logic [1:0] SZ_OK      = 2'd0;
   localparam logic [1:0] SZ_BADCODE = 2'd1;
   localparam logic [1:0] SZ_BADVER  = 2'd2;
   localparam logic [1:0] SZ_NONE    = 2'd3;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_WREQ  = 3'd1,
      SQ_WWAIT = 3'd2,
      SQ_RREQ  = 3'd3,
      SQ_RWAIT = 3'd4,
      SQ_FIN   = 3'd5
   } seq_state_e;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
   import sar_pkg::*;
#(
   parameter int                ADDR_W    = 7,
   parameter int                DATA_W    = 8,
   parameter int                NREG      = 3,
   parameter int                IDX_W     = 2,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 7'h5A,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 7'h35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_rd,
   output logic [DATA_W-1:0] cmd_wdata,
   output logic              cmd_stop,
   input  logic              rsp_valid,
   input  logic              rsp_nack,
   output logic              cap_clr,
   output logic              cap_we,
   output logic [IDX_W-1:0]  cap_idx,
   output logic              fin,
   output logic              bus_fail
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

   seq_state_e       st_q;
   logic [IDX_W-1:0] idx_q;
   logic             fail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         idx_q  <= '0;
         fail_q <= 1'b0;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  st_q   <= SQ_WREQ;
                  idx_q  <= '0;
                  fail_q <= 1'b0;
               end
            end
            SQ_WREQ: begin
               if (cmd_ready) st_q <= SQ_WWAIT;
            end
            SQ_WWAIT: begin
               if (rsp_valid) begin
                  if (rsp_nack) begin
                     fail_q <= 1'b1;
                     st_q   <= SQ_FIN;
                  end else begin
                     st_q <= SQ_RREQ;
                  end
               end
            end
            SQ_RREQ: begin
               if (cmd_ready) st_q <= SQ_RWAIT;
            end
            SQ_RWAIT: begin
               if (rsp_valid) begin
                  if (rsp_nack) begin
                     fail_q <= 1'b1;
                     st_q   <= SQ_FIN;
                  end else if (idx_q == LAST_IDX) begin
                     st_q <= SQ_FIN;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= SQ_WREQ;
                  end
               end
            end
            SQ_FIN:  st_q <= SQ_IDLE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   // command channel
   always_comb begin
      cmd_valid = (st_q == SQ_WREQ) || (st_q == SQ_RREQ);
      cmd_rd    = (st_q == SQ_RREQ);
      cmd_addr  = cmd_rd ? DATA_ADDR : CMD_ADDR;
      cmd_wdata = cmd_rd ? '0 : DATA_W'(idx_q);
      cmd_stop  = 1'b1;
   end

   assign busy     = (st_q != SQ_IDLE);
   assign cap_clr  = (st_q == SQ_IDLE) && start;
   assign cap_we   = (st_q == SQ_RWAIT) && rsp_valid && !rsp_nack;
   assign cap_idx  = idx_q;
   assign fin      = (st_q == SQ_FIN);
   assign bus_fail = fail_q;

endmodule

// File: rtl/sar_capture.sv
module sar_capture #(
   parameter int DATA_W         = 8,
   parameter int NREG           = 3,
   parameter int IDX_W          = 2,
   parameter bit CLEAR_ON_START = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   we,
   input  logic [IDX_W-1:0]       idx,
   input  logic [DATA_W-1:0]      wdata,
   output logic [NREG*DATA_W-1:0] bytes_o
);

   for (genvar g = 0; g < NREG; g++) begin : g_byte
      logic [DATA_W-1:0] q;
      logic              hit;

      assign hit = we && (idx == IDX_W'(g));

      if (CLEAR_ON_START) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (clr) q <= '0;
            else if (hit) q <= wdata;
         end
      end else begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata;
         end
      end

      assign bytes_o[g*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/sar_size_decode.sv
module sar_size_decode
   import sar_pkg::*;
#(
   parameter int VER_W  = 3,
   parameter int CODE_W = 4,
   parameter int KB_W   = 10
) (
   input  logic [VER_W-1:0]  ver_code,
   input  logic [CODE_W-1:0] size_code,
   output logic [KB_W-1:0]   size_kb,
   output logic [1:0]        size_stat
);

   localparam logic [KB_W-1:0] KB128 = KB_W'(128);
   localparam logic [KB_W-1:0] KB192 = KB_W'(192);
   localparam logic [KB_W-1:0] KB256 = KB_W'(256);
   localparam logic [KB_W-1:0] KB384 = KB_W'(384);
   localparam logic [KB_W-1:0] KB512 = KB_W'(512);
   localparam logic [VER_W-1:0] VER_WIDE = VER_W'(3);

   logic [KB_W-1:0] early_kb, wide_kb;
   logic            early_ok, wide_ok;

   // early family: three sizes, step of four codes
   always_comb begin
      early_ok = 1'b1;
      unique case (size_code)
         CODE_W'(0): early_kb = KB128;
         CODE_W'(4): early_kb = KB192;
         CODE_W'(8): early_kb = KB256;
         default: begin
            early_kb = '0;
            early_ok = 1'b0;
         end
      endcase
   end

   // wide family: five sizes, step of two codes
   always_comb begin
      wide_ok = 1'b1;
      unique case (size_code)
         CODE_W'(0): wide_kb = KB128;
         CODE_W'(2): wide_kb = KB192;
         CODE_W'(4): wide_kb = KB256;
         CODE_W'(6): wide_kb = KB384;
         CODE_W'(8): wide_kb = KB512;
         default: begin
            wide_kb = '0;
            wide_ok = 1'b0;
         end
      endcase
   end

   always_comb begin
      if (ver_code < VER_WIDE) begin
         size_kb   = early_kb;
         size_stat = early_ok ? SZ_OK : SZ_BADCODE;
      end else if (ver_code == VER_WIDE) begin
         size_kb   = wide_kb;
         size_stat = wide_ok ? SZ_OK : SZ_BADCODE;
      end else begin
         size_kb   = '0;
         size_stat = SZ_BADVER;
      end
   end

endmodule

// File: rtl/sar_result.sv
module sar_result
   import sar_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                KB_W      = 10,
   parameter logic [DATA_W-1:0] EXPECT_ID = 8'h83
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fin,
   input  logic              bus_fail,
   input  logic [DATA_W-1:0] id1,
   input  logic [KB_W-1:0]   kb_in,
   input  logic [1:0]        stat_in,
   output logic              done,
   output logic [1:0]        result,
   output logic [KB_W-1:0]   size_kb,
   output logic [1:0]        size_stat
);

   logic [1:0] res_d;

   always_comb begin
      if (bus_fail)              res_d = RES_BUS;
      else if (id1 != EXPECT_ID) res_d = RES_ID;
      else                       res_d = RES_OK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         result    <= RES_OK;
         size_kb   <= '0;
         size_stat <= SZ_NONE;
      end else if (clr) begin
         done      <= 1'b0;
         result    <= RES_OK;
         size_kb   <= '0;
         size_stat <= SZ_NONE;
      end else if (fin) begin
         done      <= 1'b1;
         result    <= res_d;
         size_kb   <= bus_fail ? '0 : kb_in;
         size_stat <= bus_fail ? SZ_NONE : stat_in;
      end
   end

endmodule

// File: rtl/sar_idreader.sv
module sar_idreader
   import sar_pkg::*;
#(
   parameter int                ADDR_W         = 7,
   parameter int                DATA_W         = 8,
   parameter int                KB_W           = 10,
   parameter int                VER_W          = 3,
   parameter int                CODE_LSB       = 4,
   parameter logic [ADDR_W-1:0] CMD_ADDR       = 7'h5A,
   parameter logic [ADDR_W-1:0] DATA_ADDR      = 7'h35,
   parameter logic [DATA_W-1:0] EXPECT_ID      = 8'h83,
   parameter bit                CLEAR_ON_START = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_rd,
   output logic [DATA_W-1:0] cmd_wdata,
   output logic              cmd_stop,
   input  logic              rsp_valid,
   input  logic              rsp_nack,
   input  logic [DATA_W-1:0] rsp_rdata,
   output logic [DATA_W-1:0] id1,
   output logic [DATA_W-1:0] id2,
   output logic [DATA_W-1:0] ver_byte,
   output logic [VER_W-1:0]  ver_code,
   output logic [KB_W-1:0]   size_kb,
   output logic [1:0]        size_stat,
   output logic [1:0]        result,
   output logic              err
);

   localparam int NREG   = 3;
   localparam int IDX_W  = $clog2(NREG);
   localparam int CODE_W = DATA_W - CODE_LSB;

   // elaboration-time parameter checks
   if (CMD_ADDR == DATA_ADDR) begin : g_bad_addr
      $error("selection and data addresses must differ");
   end
   if (KB_W < 10) begin : g_bad_kb
      $error("KB_W too narrow for 512");
   end
   if (DATA_W < 8 || CODE_LSB <= VER_W || CODE_W < 4) begin : g_bad_fields
      $error("version byte fields do not fit");
   end

   logic                   cap_clr, cap_we, fin, bus_fail;
   logic [IDX_W-1:0]       cap_idx;
   logic [NREG*DATA_W-1:0] bytes_w;
   logic [KB_W-1:0]        dec_kb;
   logic [1:0]             dec_stat;

   sar_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W),
      .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata), .cmd_stop(cmd_stop),
      .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
      .cap_clr(cap_clr), .cap_we(cap_we), .cap_idx(cap_idx),
      .fin(fin), .bus_fail(bus_fail)
   );

   sar_capture #(
      .DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W),
      .CLEAR_ON_START(CLEAR_ON_START)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .clr(cap_clr), .we(cap_we),
      .idx(cap_idx), .wdata(rsp_rdata), .bytes_o(bytes_w)
   );

   assign id1      = bytes_w[0*DATA_W +: DATA_W];
   assign id2      = bytes_w[1*DATA_W +: DATA_W];
   assign ver_byte = bytes_w[2*DATA_W +: DATA_W];
   assign ver_code = ver_byte[VER_W-1:0];

   sar_size_decode #(
      .VER_W(VER_W), .CODE_W(4), .KB_W(KB_W)
   ) u_dec (
      .ver_code(ver_code),
      .size_code(ver_byte[CODE_LSB +: 4]),
      .size_kb(dec_kb),
      .size_stat(dec_stat)
   );

   sar_result #(
      .DATA_W(DATA_W), .KB_W(KB_W), .EXPECT_ID(EXPECT_ID)
   ) u_res (
      .clk(clk), .rst_n(rst_n), .clr(cap_clr), .fin(fin),
      .bus_fail(bus_fail), .id1(id1), .kb_in(dec_kb), .stat_in(dec_stat),
      .done(done), .result(result), .size_kb(size_kb), .size_stat(size_stat)
   );

   assign err = (result != RES_OK);

endmodule

// File: rtl/sar_idreader_chk.sv
module sar_idreader_chk
   import sar_pkg::*;
#(
   parameter int                ADDR_W    = 7,
   parameter int                DATA_W    = 8,
   parameter int                KB_W      = 10,
   parameter int                VER_W     = 3,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 7'h5A,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 7'h35,
   parameter logic [DATA_W-1:0] EXPECT_ID = 8'h83
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              cmd_rd,
   input logic [DATA_W-1:0] cmd_wdata,
   input logic [DATA_W-1:0] id1,
   input logic [VER_W-1:0]  ver_code,
   input logic [KB_W-1:0]   size_kb,
   input logic [1:0]        size_stat,
   input logic [1:0]        result
);

   AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_rd |-> cmd_addr == CMD_ADDR); // R1

   AST_RD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_rd |-> cmd_addr == DATA_ADDR); // R1

   AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_rd |-> cmd_wdata < DATA_W'(3)); // R3

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr)
                                   && $stable(cmd_rd) && $stable(cmd_wdata)); // R4

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cmd_valid); // R11

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R11

   AST_ID_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      done && result == RES_OK |-> id1 == EXPECT_ID); // R9

   AST_BADVER_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      done && size_stat == SZ_BADVER |-> ver_code > VER_W'(3) && size_kb == '0); // R8

   AST_BUS_NODECODE: assert property (@(posedge clk) disable iff (!rst_n)
      done && result == RES_BUS |-> size_stat == SZ_NONE && size_kb == '0); // R10

endmodule

bind sar_idreader sar_idreader_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KB_W(KB_W), .VER_W(VER_W),
   .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR), .EXPECT_ID(EXPECT_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
   .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata), .id1(id1), .ver_code(ver_code),
   .size_kb(size_kb), .size_stat(size_stat), .result(result)
);

// File: tb/sar_idreader_tb_top.sv
`timescale 1ns/1ps
module sar_idreader_tb_top;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       start_main = 1'b0, start_stub = 1'b0;
   logic       start;
   logic       busy, done, cmd_valid, cmd_rd, cmd_stop, err;
   logic       cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_nack = 1'b0;
   logic [6:0] cmd_addr;
   logic [7:0] cmd_wdata, id1, id2, ver_byte;
   logic [7:0] rsp_rdata = 8'h00;
   logic [2:0] ver_code;
   logic [9:0] size_kb;
   logic [1:0] size_stat, result;

   assign start = start_main | start_stub;

   sar_idreader dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata), .cmd_stop(cmd_stop),
      .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata),
      .id1(id1), .id2(id2), .ver_byte(ver_byte), .ver_code(ver_code),
      .size_kb(size_kb), .size_stat(size_stat), .result(result), .err(err)
   );

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  finished = 0;
   logic [7:0] m_reg [3];
   int  m_fail = -1;
   int  cmd_cnt = 0;
   bit  coinc_arm = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // expected decode: returns {status, kb}
   function automatic logic [11:0] exp_dec(input logic [7:0] v);
      int ver = v % 8;
      int sc  = v / 16;
      int kb  = 0;
      int st  = 1;
      if (ver > 3) begin
         st = 2;
      end else if (ver == 3) begin
         if (sc % 2 == 0 && sc <= 8) begin
            st = 0;
            kb = (sc == 6) ? 384 : (sc == 8) ? 512 : 128 + sc * 32;
         end
      end else begin
         if (sc == 0 || sc == 4 || sc == 8) begin
            st = 0;
            kb = 128 + sc * 16;
         end
      end
      return {st[1:0], kb[9:0]};
   endfunction

   // byte-master stub
   initial begin : stub
      bit         vp = 0, rp = 0, outst = 0;
      logic [6:0] ap = '0;
      logic       rdp = 0, sp = 0;
      logic [7:0] wp = '0;
      int         lat = 0, cur = 0;
      forever begin
         @(negedge clk);
         start_stub = 1'b0;
         if (!rst_n) begin
            vp = 0; rp = 0; outst = 0; lat = 0;
            cmd_ready = 1'b0; rsp_valid = 1'b0;
         end else begin
            if (vp && rp) begin
               chk(ap == ((cmd_cnt % 2 == 0) ? 7'h5A : 7'h35), "R1", "cmd_addr",
                   int'(ap), (cmd_cnt % 2 == 0) ? 32'h5A : 32'h35);
               chk(rdp == (cmd_cnt % 2 == 1), "R1", "cmd_rd", int'(rdp), cmd_cnt % 2);
               if (cmd_cnt % 2 == 0)
                  chk(wp == 8'(cmd_cnt / 2), "R3", "offset", int'(wp), cmd_cnt / 2);
               chk(sp == 1'b1, "R2", "cmd_stop", int'(sp), 1);
               chk(cmd_cnt < 6, "R2", "command count", cmd_cnt + 1, 6);
               cur = cmd_cnt;
               cmd_cnt++;
               outst = 1;
               lat = 1 + int'($urandom % 3);
            end else if (vp && !rp) begin
               chk(cmd_valid && cmd_addr == ap && cmd_rd == rdp && cmd_wdata == wp,
                   "R4", "hold while stalled", int'(cmd_addr), int'(ap));
            end
            rsp_valid = 1'b0;
            rsp_nack  = 1'b0;
            if (outst) begin
               lat--;
               if (lat == 0) begin
                  rsp_valid = 1'b1;
                  rsp_nack  = (cur == m_fail);
                  rsp_rdata = (cur % 2 == 1) ? m_reg[cur / 2] : 8'($urandom);
                  outst = 0;
                  if (coinc_arm && (cur == 5 || cur == m_fail)) start_stub = 1'b1;
               end
            end
            if (outst || rsp_valid)
               chk(!cmd_valid, "R2", "command while outstanding", int'(cmd_valid), 0);
            cmd_ready = !outst && ($urandom % 4 != 0);
            vp = cmd_valid; rp = cmd_ready;
            ap = cmd_addr; rdp = cmd_rd; wp = cmd_wdata; sp = cmd_stop;
         end
      end
   end

   task automatic run_case(input logic [7:0] i1, input logic [7:0] i2,
                           input logic [7:0] vb, input int fail,
                           input bit mid, input bit coinc);
      int          t = 0;
      int          exp_n;
      bit          bus;
      logic [11:0] d;
      logic [7:0]  e1, e2, e3;
      m_reg[0] = i1; m_reg[1] = i2; m_reg[2] = vb;
      m_fail = fail; coinc_arm = coinc; cmd_cnt = 0;
      @(negedge clk);
      start_main = 1'b1;
      @(negedge clk);
      start_main = 1'b0;
      chk(busy && !done, "R11", "busy after start", int'(busy), 1);
      if (mid) begin
         repeat (3) @(negedge clk);
         start_main = 1'b1;
         @(negedge clk);
         start_main = 1'b0;
      end
      while (!done && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk(done, "R11", "done reached", int'(done), 1);
      bus   = (fail >= 0 && fail < 6);
      exp_n = bus ? fail + 1 : 6;
      chk(cmd_cnt == exp_n, "R10", "commands issued", cmd_cnt, exp_n);
      e1 = (!bus || fail > 1) ? i1 : 8'h00;
      e2 = (!bus || fail > 3) ? i2 : 8'h00;
      e3 = (!bus) ? vb : 8'h00;
      chk(id1 == e1, "R3", "id1", int'(id1), int'(e1));
      chk(id2 == e2, "R3", "id2", int'(id2), int'(e2));
      chk(ver_byte == e3, "R3", "ver_byte", int'(ver_byte), int'(e3));
      if (bus) begin
         chk(result == 2'd1 && err, "R10", "bus result", int'(result), 1);
         chk(size_stat == 2'd3 && size_kb == 0, "R10", "no decode", int'(size_stat), 3);
      end else begin
         d = exp_dec(vb);
         chk(ver_code == vb[2:0], "R5", "ver_code", int'(ver_code), int'(vb[2:0]));
         chk(size_kb == d[9:0], (vb[2:0] > 3) ? "R8" : (vb[2:0] == 3) ? "R7" : "R6",
             "size_kb", int'(size_kb), int'(d[9:0]));
         chk(size_stat == d[11:10], (vb[2:0] > 3) ? "R8" : (vb[2:0] == 3) ? "R7" : "R6",
             "size_stat", int'(size_stat), int'(d[11:10]));
         chk(result == ((i1 == 8'h83) ? 2'd0 : 2'd2), "R9", "result",
             int'(result), (i1 == 8'h83) ? 0 : 2);
         chk(err == (i1 != 8'h83), "R9", "err", int'(err), int'(i1 != 8'h83));
      end
      repeat (4) @(negedge clk);
      chk(cmd_cnt == exp_n && done && !busy, "R11", "no extra run",
          cmd_cnt, exp_n);
      coinc_arm = 0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!busy && !done && !cmd_valid, "R12", "reset control", int'(busy), 0);
      chk(id1 == 0 && id2 == 0 && ver_byte == 0, "R12", "reset bytes", int'(id1), 0);
      chk(result == 0 && !err && size_kb == 0 && size_stat == 2'd3, "R12",
          "reset results", int'(size_stat), 3);
      rst_n = 1'b1;
      // directed: each size table entry and edge
      run_case(8'h83, 8'h20, 8'h00, -1, 0, 0); // R6 128
      run_case(8'h83, 8'h20, 8'h41, -1, 0, 0); // R6 192
      run_case(8'h83, 8'h20, 8'h82, -1, 0, 0); // R6 256
      run_case(8'h83, 8'h20, 8'h21, -1, 0, 0); // R6 bad code
      run_case(8'h83, 8'h20, 8'h23, -1, 0, 0); // R7 192
      run_case(8'h83, 8'h20, 8'h63, -1, 0, 0); // R7 384
      run_case(8'h83, 8'h20, 8'h83, -1, 0, 0); // R7 512
      run_case(8'h83, 8'h20, 8'h93, -1, 0, 0); // R7 bad code
      run_case(8'h83, 8'h20, 8'h4B, -1, 0, 0); // R5 bit 3 ignored
      run_case(8'h83, 8'h20, 8'h04, -1, 0, 0); // R8
      run_case(8'h83, 8'h20, 8'h87, -1, 0, 0); // R8
      run_case(8'h82, 8'h20, 8'h03, -1, 0, 0); // R9 mismatch
      run_case(8'h83, 8'h11, 8'h03, 0, 0, 0);  // R10 first write
      run_case(8'h83, 8'h11, 8'h03, 5, 0, 0);  // R10 last read
      run_case(8'h83, 8'h11, 8'h03, 2, 0, 1);  // R10 with coinciding start
      run_case(8'h83, 8'h11, 8'h43, -1, 1, 1); // R11 mid and final start
      // random runs
      for (int k = 0; k < 40; k++) begin
         logic [7:0] a, b, v;
         int f;
         a = ($urandom % 4 != 0) ? 8'h83 : 8'($urandom);
         b = 8'($urandom);
         v = 8'($urandom);
         f = ($urandom % 4 == 0) ? int'($urandom % 6) : -1;
         run_case(a, b, v, f, ($urandom % 5 == 0), ($urandom % 3 == 0));
      end
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule